// File: doc/BRIEF.md
# Framebuffer Byte-to-Pixel Serializer

This block turns a one-bit-per-pixel framebuffer into a serial video level during the visible part of each scan line. A timing generator tells it when a frame begins and when a line's picture window is open. The block then reads bytes through a synchronous read port and shows each byte as eight pixels, most significant bit first, with every pixel held for a fixed number of clocks. Bytes follow one another with no gap, so a line is one continuous, time-exact run of pixels.

The read pointer returns to a fixed base address at every frame start. It then advances by one for every byte shown and carries on from line to line with no stride, so line n begins at base plus 52·n, modulo 2^16. While the line window is closed, the output is forced low so that it is black before the sync interval. The read port has one clock of latency. The pointer always rests on the next byte to be shown, so that byte is already waiting on the data bus when the window opens or when the current byte ends.

Top module: `fb_pixel_serializer`

## Requirements
- R1: While reset is asserted and after it is released, `video` is 0 and `rd_addr` equals BASE_ADDR (default 16'h0100).
- R2: A one-cycle `frame_start` pulse, given while `line_active` is low, sets `rd_addr` to BASE_ADDR at the next clock edge. `line_active` must not rise on the clock edge that follows that pulse.
- R3: The first clock edge that samples `line_active` high loads the byte on `rd_data`. Starting in the next cycle, `video` shows that byte's bit 7, then bits 6 down to 0, each held for 3 clocks.
- R4: A line shows exactly 52 bytes (1248 clocks). After that, `video` stays 0 until `line_active` falls and rises again, even if it stays high.
- R5: `rd_addr` increases by exactly one each time a byte is loaded and otherwise holds. With line n counted from the last frame start, `rd_addr` equals BASE_ADDR + 52·n when that line begins and BASE_ADDR + 52·(n+1) after it ends.
- R6: Within a line, bytes are loaded exactly 24 clocks apart, with no idle pixel between bytes.
- R7: Whenever `line_active` is low, `video` is 0. This includes a line cut short; such a line leaves `rd_addr` advanced by the number of bytes it loaded.
- R8: `rd_addr` is 16 bits wide and wraps from 16'hFFFF to 16'h0000 in the middle of a line without breaking the pixel stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| line_active | input | 1 | High while the picture window of a line is open |
| rd_addr | output | 16 | Framebuffer read address, with read data one clock later |
| rd_data | input | 8 | Framebuffer byte returned by the memory |
| video | output | 1 | Serial pixel level, 1 = white |

## Verification
The hardest case to reach is a line that wraps the 16-bit address space. With the default base, that would take more than a thousand lines of stimulus. The bench therefore overrides the base to 16'hFFC8, so the second line crosses 16'hFFFF to 16'h0000 in its middle. The bench compares every clock against a pixel queue built from its own memory image. It also cuts a line short after 100 clocks and checks that the pointer has moved by exactly the five bytes already loaded.

// File: rtl/fb_pixel_serializer.sv
module fb_pixel_serializer #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
  parameter int BYTE_W = 8,
  parameter int BYTES_PER_LINE = 52,
  parameter int PIX_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_active,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              video
);
  localparam int PH_W  = (PIX_CLKS > 1) ? $clog2(PIX_CLKS) : 1;
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int BC_W  = (BYTES_PER_LINE > 1) ? $clog2(BYTES_PER_LINE) : 1;
  localparam logic [PH_W-1:0]  LAST_PH   = PH_W'(PIX_CLKS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);
  localparam logic [BC_W-1:0]  LAST_BYTE = BC_W'(BYTES_PER_LINE - 1);

  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] shreg;
  logic [PH_W-1:0]   phase;
  logic [BIT_W-1:0]  bitc;
  logic [BC_W-1:0]   bytec;
  logic              running;
  logic              done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= BASE_ADDR;
      shreg   <= '0;
      phase   <= '0;
      bitc    <= '0;
      bytec   <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (frame_start) begin
      ptr     <= BASE_ADDR;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (!line_active) begin
      running <= 1'b0;
      done    <= 1'b0;
    end else if (!running && !done) begin
      shreg   <= rd_data;
      ptr     <= ptr + 1'b1;
      running <= 1'b1;
      phase   <= '0;
      bitc    <= '0;
      bytec   <= '0;
    end else if (running) begin
      if (phase == LAST_PH) begin
        phase <= '0;
        if (bitc == LAST_BIT) begin
          bitc <= '0;
          if (bytec == LAST_BYTE) begin
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            shreg <= rd_data;
            ptr   <= ptr + 1'b1;
            bytec <= bytec + 1'b1;
          end
        end else begin
          shreg <= shreg << 1;
          bitc  <= bitc + 1'b1;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign rd_addr = ptr;
  assign video   = running & line_active & shreg[BYTE_W-1];
endmodule

// File: rtl/fb_pixel_serializer_chk.sv
module fb_pixel_serializer_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_active,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              video
);
  logic [ADDR_W-1:0] prev;
  logic [5:0]        gap;
  logic              in_line;
  logic              moved;

  assign moved = (rd_addr != prev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= BASE_ADDR;
      gap     <= '0;
      in_line <= 1'b0;
    end else begin
      prev <= rd_addr;
      if (moved) begin
        gap     <= 6'd1;
        in_line <= line_active;
      end else begin
        if (gap != 6'h3F) gap <= gap + 6'd1;
        if (!line_active) in_line <= 1'b0;
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (rd_addr == BASE_ADDR) && !video); // R1
  AST_FRAME_BASE: assert property (@(posedge clk) disable iff (!rst_n) frame_start |=> rd_addr == BASE_ADDR); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (rd_addr != $past(rd_addr)) && !$past(frame_start) |-> rd_addr == $past(rd_addr) + 1'b1); // R5
  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n) !line_active && !frame_start |=> $stable(rd_addr)); // R5
  AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (!rst_n) moved && in_line && line_active |-> gap == 6'd24); // R6
  AST_IDLE_BLACK: assert property (@(posedge clk) disable iff (!rst_n) !line_active |-> !video); // R7
endmodule

bind fb_pixel_serializer fb_pixel_serializer_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_active(line_active),
  .rd_addr(rd_addr), .video(video)
);

// File: tb/fb_pixel_serializer_tb.sv
module fb_pixel_serializer_tb;
  localparam logic [15:0] BASE = 16'hFFC8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        line_active = 1'b0;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = 8'h00;
  logic        video;

  logic [7:0]  mem [0:1023];
  logic        expq [$];
  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;
  logic [15:0] eptr;

  always #10 clk = ~clk;
  always @(posedge clk) rd_data <= mem[rd_addr[9:0]];

  fb_pixel_serializer #(.BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_active(line_active),
    .rd_addr(rd_addr), .rd_data(rd_data), .video(video)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic tick();
    logic e;
    string tag;
    @(negedge clk);
    tag = (expq.size() > 0) ? "R3" : (line_active ? "R4" : "R7");
    e = (expq.size() > 0) ? expq.pop_front() : 1'b0;
    checks++;
    if (video !== e) begin
      fails++;
      $display("FAIL %s video at %0t: got %b expected %b", tag, $time, video, e);
    end
  endtask

  task automatic chk_addr(input logic [15:0] exp, input string tag);
    checks++;
    if (rd_addr !== exp) begin
      fails++;
      $display("FAIL %s rd_addr got %h expected %h", tag, rd_addr, exp);
    end
  endtask

  task automatic open_line();
    for (int b = 0; b < 52; b++) begin
      logic [15:0] a;
      a = eptr + 16'(b);
      for (int k = 7; k >= 0; k--)
        for (int r = 0; r < 3; r++) expq.push_back(mem[a[9:0]][k]);
    end
    line_active = 1'b1;
  endtask

  task automatic full_line(input int extra);
    chk_addr(eptr, "R5 line start");
    open_line();
    repeat (1248 + extra) tick();
    line_active = 1'b0;
    expq.delete();
    eptr = eptr + 16'd52;
    tick();
    chk_addr(eptr, "R5 line end");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      case ((i / 64) % 4)
        0: mem[i] = 8'hAA;
        1: mem[i] = 8'(i) ^ 8'h5C;
        2: mem[i] = i[0] ? 8'hFF : 8'h00;
        default: mem[i] = {i[3:0], ~i[3:0]};
      endcase
    end
    repeat (3) @(negedge clk);
    checks++;
    if (video !== 1'b0 || rd_addr !== BASE) begin
      fails++;
      $display("FAIL R1 reset video=%b rd_addr=%h expected 0 %h", video, rd_addr, BASE);
    end
    rst_n = 1'b1;
    repeat (3) tick();
    chk_addr(BASE, "R1 after reset");
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    repeat (4) tick();
    eptr = BASE;
    chk_addr(eptr, "R2 frame start");

    full_line(0);
    repeat (10) tick();
    full_line(30);            // R4 window held open, R8 wrap inside this line
    repeat (7) tick();
    full_line(0);
    repeat (5) tick();

    chk_addr(eptr, "R7 before cut line");
    open_line();
    repeat (100) tick();
    line_active = 1'b0;
    expq.delete();
    repeat (6) tick();
    chk_addr(eptr + 16'd5, "R7 cut line advance");

    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    repeat (4) tick();
    eptr = BASE;
    chk_addr(eptr, "R2 second frame");
    full_line(0);
    full_line(3);
    repeat (5) tick();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got timeout expected completion");
    summary();
  end
endmodule